// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block supervises software running on a small 8-bit controller. It divides the oscillator clock in three stages: a fixed base divider, a prescaler that software sets to one of eight power-of-two ratios, and a 14-bit main counter. When the main counter wraps and the unit is armed, it drives a system reset pulse of fixed length. After the pulse, the whole divider chain starts again from zero.

Software reaches the unit through one 8-bit control register. The register holds an arm bit, a self-clearing service bit, an idle-run bit and the prescaler code. Software must write the service bit before the period runs out. This restarts the prescaler and the main counter. The idle-run bit decides whether the chain keeps counting while the system is in idle mode. The chain runs freely whether or not the unit is armed. Only the reset output is gated by the arm bit.

Top module: `wdog_unit`

## Requirements
- R1: After reset, the control register reads 0x00 and the reset output is low.
- R2: A write to address CTRL_ADDR (default 0x8F) loads the fields as follows: bit 7 is arm, bit 6 is service, bit 5 is idle-run and bits 2..0 are the prescaler code. Bits 4 and 3 always read 0. A write to any other address leaves the register unchanged.
- R3: The service bit reads 1 for exactly one cycle after it is written as 1, then returns to 0 by itself. The cycle in which it reads 0 again is the first cycle of the chain's restart from zero.
- R4: The prescaler code c selects a ratio of 2^(c+1): code 0 gives 2 and code 7 gives 256. When armed, the reset output rises exactly BASE_DIV × 2^(c+1) × 2^CNT_W clock cycles after the restart.
- R5: Each timeout produces one reset pulse that stays high for exactly RST_LEN cycles.
- R6: The chain is held at zero while the pulse is high. The next pulse rises one full period after the pulse ends.
- R7: A timeout while the arm bit is 0 produces no reset pulse.
- R8: While idle_i is high and idle-run is 0, the chain holds its state. Each such cycle delays the timeout by one cycle.
- R9: While idle-run is 1, the chain counts during idle at its normal rate.
- R10: A service write before the timeout restarts the full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| idle_i | input | 1 | System idle-mode indication |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register write address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Control register read value |
| wdt_rst_o | output | 1 | System reset pulse |

## Verification
The bench builds the unit with BASE_DIV = 3, CNT_W = 4 and RST_LEN = 5. A full period is then 96 cycles at prescaler code 0 and 12288 cycles at code 7. These values make it possible to measure exact periods at the smallest, a middle and the largest ratio. They also allow back-to-back timeouts with the restart after a pulse, idle freezes of a known length inside one period, and a service write part way through a period, all within a short run.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int unsigned PS_SEL_W = 3;
  localparam int unsigned BIT_EN   = 7;
  localparam int unsigned BIT_CLR  = 6;
  localparam int unsigned BIT_IDL  = 5;

  typedef struct packed {
    logic                en;
    logic                clr;
    logic                idl_en;
    logic [PS_SEL_W-1:0] ps_sel;
  } wdog_ctrl_t;
endpackage

// File: rtl/wdog_ctrl_reg.sv
`timescale 1ns/1ps
module wdog_ctrl_reg
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h8F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output wdog_ctrl_t        ctrl_o,
  output logic [DATA_W-1:0] rd_data
);
  wdog_ctrl_t cur_q, nxt;
  logic       hit;

  assign hit = wr_en && (wr_addr == CTRL_ADDR);

  // Service bit lives one cycle unless rewritten.
  always_comb begin
    nxt     = cur_q;
    nxt.clr = 1'b0;
    if (hit) begin
      nxt.en     = wr_data[BIT_EN];
      nxt.clr    = wr_data[BIT_CLR];
      nxt.idl_en = wr_data[BIT_IDL];
      nxt.ps_sel = wr_data[PS_SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= nxt;
  end

  always_comb begin
    rd_data                 = '0;
    rd_data[BIT_EN]         = cur_q.en;
    rd_data[BIT_CLR]        = cur_q.clr;
    rd_data[BIT_IDL]        = cur_q.idl_en;
    rd_data[PS_SEL_W-1:0]   = cur_q.ps_sel;
  end

  assign ctrl_o = cur_q;

  a_r3_clr_self: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q.clr && !(wr_en && wr_addr == CTRL_ADDR && wr_data[BIT_CLR])) |=> !rd_data[BIT_CLR]);

  a_r2_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != CTRL_ADDR) |=>
      ($stable(rd_data[BIT_EN]) && $stable(rd_data[BIT_IDL]) && $stable(rd_data[PS_SEL_W-1:0])));
endmodule

// File: rtl/wdog_chain.sv
`timescale 1ns/1ps
module wdog_chain #(
  parameter int unsigned BASE_DIV = 12,
  parameter int unsigned CNT_W    = 14,
  parameter int unsigned SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] ps_sel_i,
  output logic             timeout_o
);
  localparam int unsigned BASE_W = (BASE_DIV > 2) ? $clog2(BASE_DIV) : 1;
  localparam int unsigned PRE_W  = 1 << SEL_W;
  localparam logic [BASE_W-1:0] BASE_LAST = BASE_W'(BASE_DIV - 1);

  logic [BASE_W-1:0] base_q, base_d;
  logic [PRE_W-1:0]  pre_q, pre_d, pre_mask;
  logic [CNT_W-1:0]  main_q, main_d;
  logic              base_tick, pre_tick;

  // Ratio 2^(sel+1): prescaler ticks when its low sel+1 bits are all ones.
  always_comb begin
    for (int i = 0; i < PRE_W; i++) pre_mask[i] = (i <= int'(ps_sel_i));
  end

  assign base_tick = run_i && (base_q == BASE_LAST);
  assign pre_tick  = base_tick && ((pre_q & pre_mask) == pre_mask);
  assign timeout_o = pre_tick && (&main_q);

  always_comb begin
    base_d = base_q;
    pre_d  = pre_q;
    main_d = main_q;
    if (clr_i) begin
      base_d = '0;
      pre_d  = '0;
      main_d = '0;
    end else if (run_i) begin
      base_d = base_tick ? '0 : base_q + 1'b1;
      if (base_tick) pre_d  = pre_q + 1'b1;
      if (pre_tick)  main_d = main_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      pre_q  <= '0;
      main_q <= '0;
    end else begin
      base_q <= base_d;
      pre_q  <= pre_d;
      main_q <= main_d;
    end
  end

  a_r8_idle_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i) |=> ($stable(base_q) && $stable(pre_q) && $stable(main_q)));

  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (base_q == '0 && pre_q == '0 && main_q == '0));

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && !clr_i) |=> (main_q == '0 && base_q == '0));
endmodule

// File: rtl/wdog_pulse.sv
`timescale 1ns/1ps
module wdog_pulse #(
  parameter int unsigned RST_LEN = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int unsigned LEN_W = $clog2(RST_LEN + 1);

  logic             act_q, act_d;
  logic [LEN_W-1:0] left_q, left_d;

  always_comb begin
    act_d  = act_q;
    left_d = left_q;
    if (act_q) begin
      if (left_q == '0) act_d = 1'b0;
      else              left_d = left_q - 1'b1;
    end else if (fire_i) begin
      act_d  = 1'b1;
      left_d = LEN_W'(RST_LEN - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      left_q <= '0;
    end else begin
      act_q  <= act_d;
      left_q <= left_d;
    end
  end

  assign pulse_o = act_q;

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && left_q != '0) |=> pulse_o);

  a_r5_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(fire_i));
endmodule

// File: rtl/wdog_unit.sv
`timescale 1ns/1ps
module wdog_unit
  import wdog_pkg::*;
#(
  parameter logic [7:0]  CTRL_ADDR = 8'h8F,
  parameter int unsigned BASE_DIV  = 12,
  parameter int unsigned CNT_W     = 14,
  parameter int unsigned RST_LEN   = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_i,
  input  logic       reg_we_i,
  input  logic [7:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       wdt_rst_o
);
  logic       rst_meta_q, rst_sync_q;
  wdog_ctrl_t ctrl;
  logic       run, chain_clr, timeout, fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  wdog_ctrl_reg #(.ADDR_W(8), .DATA_W(8), .CTRL_ADDR(CTRL_ADDR)) u_reg (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr_en   (reg_we_i),
    .wr_addr (reg_addr_i),
    .wr_data (reg_wdata_i),
    .ctrl_o  (ctrl),
    .rd_data (reg_rdata_o)
  );

  assign run       = !idle_i || ctrl.idl_en;
  assign chain_clr = ctrl.clr || wdt_rst_o;

  wdog_chain #(.BASE_DIV(BASE_DIV), .CNT_W(CNT_W), .SEL_W(PS_SEL_W)) u_chain (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .run_i     (run),
    .clr_i     (chain_clr),
    .ps_sel_i  (ctrl.ps_sel),
    .timeout_o (timeout)
  );

  assign fire = timeout && ctrl.en;

  wdog_pulse #(.RST_LEN(RST_LEN)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .fire_i  (fire),
    .pulse_o (wdt_rst_o)
  );

  a_r7_armed_only: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(wdt_rst_o) |-> $past(ctrl.en));
endmodule

// File: tb/tb_wdog_unit.sv
`timescale 1ns/1ps
module tb_wdog_unit;
  localparam logic [7:0] CADDR = 8'h8F;
  localparam int B = 3;
  localparam int W = 4;
  localparam int L = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       idle_i;
  logic       reg_we_i;
  logic [7:0] reg_addr_i;
  logic [7:0] reg_wdata_i;
  logic [7:0] reg_rdata_o;
  logic       wdt_rst_o;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  wdog_unit #(.CTRL_ADDR(CADDR), .BASE_DIV(B), .CNT_W(W), .RST_LEN(L)) dut (
    .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .reg_we_i(reg_we_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .wdt_rst_o(wdt_rst_o)
  );

  function automatic int period(input int code);
    return B * (2 << code) * (1 << W);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk); @(negedge clk);
    reg_we_i = 1'b0; reg_addr_i = 8'h00; reg_wdata_i = 8'h00;
  endtask

  // Ends at the first cycle of the chain restart (R3).
  task automatic arm(input logic [7:0] cfg);
    wr(CADDR, 8'h40);
    wr(CADDR, cfg | 8'h40);
    chk("R3 service bit visible", reg_rdata_o, (cfg & 8'hE7) | 8'h40);
    @(posedge clk); @(negedge clk);
    chk("R3 service bit self-clears", reg_rdata_o, cfg & 8'hE7);
  endtask

  task automatic measure(input int lo, input int hi, output int n);
    n = 0;
    while (!wdt_rst_o && n < 20000) begin
      if (hi > lo) idle_i = (n >= lo && n < hi);
      @(posedge clk); n++; @(negedge clk);
    end
    if (hi > lo) idle_i = 1'b0;
  endtask

  task automatic width(output int w);
    w = 0;
    while (wdt_rst_o && w < 1000) begin
      w++; @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 register after reset", reg_rdata_o, 0);
    chk("R1 reset output low", wdt_rst_o, 0);
  endtask

  task automatic t_register();
    wr(CADDR, 8'hFF);
    chk("R2 all fields, rsvd zero", reg_rdata_o, 8'hE7);
    @(posedge clk); @(negedge clk);
    chk("R2 R3 after self clear", reg_rdata_o, 8'hA7);
    wr(8'h8E, 8'h00);
    chk("R2 foreign address ignored", reg_rdata_o, 8'hA7);
    wr(CADDR, 8'h00);
    chk("R2 cleared by write", reg_rdata_o, 8'h00);
  endtask

  task automatic t_period(input int code, input bit twice);
    int n, w;
    arm(8'h80 | 8'(code));
    measure(0, 0, n);
    chk($sformatf("R4 period code %0d", code), n, period(code));
    width(w);
    chk("R5 pulse width", w, L);
    if (twice) begin
      measure(0, 0, n);
      chk("R6 restart after pulse", n, period(code));
      width(w);
      chk("R5 second pulse width", w, L);
    end
    wr(CADDR, 8'h00);
  endtask

  task automatic t_disarmed();
    int hits = 0;
    arm(8'h00);
    for (int i = 0; i < 2 * period(0) + 20; i++) begin
      @(posedge clk); @(negedge clk);
      if (wdt_rst_o) hits++;
    end
    chk("R7 no pulse when disarmed", hits, 0);
  endtask

  task automatic t_idle_freeze();
    int n, w;
    arm(8'h80);
    measure(40, 90, n);
    chk("R8 idle freeze delays timeout", n, period(0) + 50);
    width(w);
    wr(CADDR, 8'h00);
  endtask

  task automatic t_idle_run();
    int n, w;
    idle_i = 1'b1;
    arm(8'hA0);
    measure(0, 0, n);
    chk("R9 counts during idle", n, period(0));
    width(w);
    idle_i = 1'b0;
    wr(CADDR, 8'h00);
  endtask

  task automatic t_service();
    int n, w;
    int hits = 0;
    arm(8'h80);
    for (int i = 0; i < 80; i++) begin
      @(posedge clk); @(negedge clk);
      if (wdt_rst_o) hits++;
    end
    wr(CADDR, 8'hC0);
    @(posedge clk); @(negedge clk);
    measure(0, 0, n);
    chk("R10 no pulse before service", hits, 0);
    chk("R10 full period after service", n, period(0));
    width(w);
    wr(CADDR, 8'h00);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; idle_i = 1'b0; reg_we_i = 1'b0;
    reg_addr_i = 8'h00; reg_wdata_i = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_register();
    t_period(0, 1'b1);
    t_period(2, 1'b0);
    t_period(7, 1'b0);
    t_disarmed();
    t_idle_freeze();
    t_idle_run();
    t_service();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule